// File: doc/BRIEF.md
# Seven-to-one video link serializer

This block turns one 28-bit pixel-rate word into four serial data lanes and a forwarded clock lane, running entirely in a bit-rate clock domain at seven times the pixel rate. Each pixel period the block takes a pixel value, three video strobes (frame valid, line valid, data valid) and a format select. It places the pixel bits into an 8-bit red, green and blue field set according to the format. It then packs those 24 bits and the strobes into four 7-bit lane words and shifts each word out most-significant bit first.

The forwarded clock lane carries a fixed per-group pattern, high for four bit periods and low for three. Each 7-bit group begins half-way through the high phase, so a receiver can find group boundaries from the clock alone. The inputs are sampled once per group, on the bit-clock edge that starts the group. The pixel-rate source only has to hold its word stable around that edge.

Top module: `cl_video_serializer`

## Requirements
- R1: While rst_ni is low, every lane_o bit is 0 and fwd_clk_o is 1.
- R2: Over the seven bit periods of every group, fwd_clk_o reads 1,1,0,0,0,1,1 in time order, so the group starts in the middle of a four-period high phase.
- R3: Each lane sends its 7-bit word w[6:0] with w[6] first and w[0] last. With R, G and B the mapped colour fields, the lane words are lane0 = {G0,R5,R4,R3,R2,R1,R0}, lane1 = {B1,B0,G5,G4,G3,G2,G1}, lane2 = {dval,fval,lval,B5,B4,B3,B2} and lane3 = {0,B7,B6,G7,G6,R7,R6}.
- R4: With fmt_i = 0 (colour), R = pix_i[7:0], G = pix_i[15:8] and B = pix_i[23:16].
- R5: With fmt_i = 1 (14-bit grey), R = pix_i[7:0], G = {2'b00, pix_i[13:8]} and B = 0.
- R6: With fmt_i = 2 (8-bit grey), R = {pix_i[1:0], 6'b0}, G = {2'b00, pix_i[7:2]} and B = 0.
- R7: With fmt_i = 3 (16-bit superframe), R = pix_i[7:0], G = pix_i[15:8] and B = 0.
- R8: fval_i, lval_i and dval_i reach their lane2 slots unchanged in every format.
- R9: All inputs are captured on the first rising clk_i edge after reset release and on every seventh edge after that. Input changes between capture edges do not alter the group being sent.
- R10: pix_i bits that the selected format does not map (pix_i[23:14] in 14-bit grey, pix_i[23:8] in 8-bit grey, pix_i[23:16] in superframe) have no effect on any lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Pixel format: 0 colour, 1 grey14, 2 grey8, 3 superframe16 |
| pix_i | input | 24 | Pixel value, LSB aligned |
| fval_i | input | 1 | Frame valid strobe |
| lval_i | input | 1 | Line valid strobe |
| dval_i | input | 1 | Data valid strobe |
| lane_o | output | 4 | Serial data lanes, bit k is lane k |
| fwd_clk_o | output | 1 | Forwarded pixel clock, 4 high / 3 low per group |

## Verification
Colour words of all ones, alternating nibbles and single walking bits separate a lane or slot swap from a correct placement. Distinct grey and superframe values show each format's shift and zero fill. Grey and superframe values carrying random upper bits show that unmapped pixel bits are dropped. Strobe combinations with random pixels isolate the lane2 strobe slots. Groups whose inputs are re-randomized after the capture edge tell a per-group capture apart from a live input path.

// File: rtl/cl_ser_pkg.sv
package cl_ser_pkg;
  localparam int unsigned LANES     = 4;
  localparam int unsigned SLOTS     = 7;
  localparam int unsigned CH_W      = 8;
  localparam int unsigned PIX_W     = 3 * CH_W;
  localparam int unsigned FMT_W     = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_RGB24  = 2'd0,
    FMT_GREY14 = 2'd1,
    FMT_GREY8  = 2'd2,
    FMT_SF16   = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [CH_W-1:0] b;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] r;
  } rgb_t;
endpackage

// File: rtl/cl_fmt_map.sv
module cl_fmt_map
  import cl_ser_pkg::*;
(
  input  logic [FMT_W-1:0] fmt_i,
  input  logic [PIX_W-1:0] pix_i,
  output rgb_t             rgb_o
);
  always_comb begin
    rgb_o = '0;
    unique case (fmt_e'(fmt_i))
      FMT_RGB24: begin
        rgb_o.r = pix_i[7:0];
        rgb_o.g = pix_i[15:8];
        rgb_o.b = pix_i[23:16];
      end
      FMT_GREY14: begin
        rgb_o.r = pix_i[7:0];
        rgb_o.g = {2'b00, pix_i[13:8]};
      end
      FMT_GREY8: begin
        rgb_o.r = {pix_i[1:0], 6'b0};
        rgb_o.g = {2'b00, pix_i[7:2]};
      end
      FMT_SF16: begin
        rgb_o.r = pix_i[7:0];
        rgb_o.g = pix_i[15:8];
      end
      default: rgb_o = '0;
    endcase
  end
endmodule

// File: rtl/cl_lane_pack.sv
module cl_lane_pack
  import cl_ser_pkg::*;
(
  input  rgb_t                         rgb_i,
  input  logic                         fval_i,
  input  logic                         lval_i,
  input  logic                         dval_i,
  output logic [LANES-1:0][SLOTS-1:0]  word_o
);
  // index 6 leaves the lane first
  always_comb begin
    word_o[0] = {rgb_i.g[0], rgb_i.r[5:0]};
    word_o[1] = {rgb_i.b[1:0], rgb_i.g[5:1]};
    word_o[2] = {dval_i, fval_i, lval_i, rgb_i.b[5:2]};
    word_o[3] = {1'b0, rgb_i.b[7:6], rgb_i.g[7:6], rgb_i.r[7:6]};
  end
endmodule

// File: rtl/cl_phase_gen.sv
module cl_phase_gen #(
  parameter int unsigned SLOTS      = 7,
  parameter int unsigned HIGH_SLOTS = 4,
  parameter int unsigned LEAD_SLOTS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic fwd_clk_o
);
  localparam int unsigned PH_W = $clog2(SLOTS);
  localparam int unsigned TAIL = SLOTS - (HIGH_SLOTS - LEAD_SLOTS);
  localparam logic [PH_W-1:0] LAST = PH_W'(SLOTS - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ph_q <= LAST;
    else if (ph_q == LAST)  ph_q <= '0;
    else                    ph_q <= ph_q + 1'b1;
  end

  assign load_o    = (ph_q == LAST);
  // ph_q names the slot now on the lanes
  assign fwd_clk_o = (ph_q < PH_W'(LEAD_SLOTS)) || (ph_q >= PH_W'(TAIL));
endmodule

// File: rtl/cl_lane_shift.sv
module cl_lane_shift #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SLOTS-1:0] word_i,
  output logic             ser_o
);
  logic [SLOTS-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= word_i;
    else             sr_q <= {sr_q[SLOTS-2:0], 1'b0};
  end

  assign ser_o = sr_q[SLOTS-1];
endmodule

// File: rtl/cl_video_serializer.sv
module cl_video_serializer
  import cl_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       fmt_i,
  input  logic [23:0]      pix_i,
  input  logic             fval_i,
  input  logic             lval_i,
  input  logic             dval_i,
  output logic [3:0]       lane_o,
  output logic             fwd_clk_o
);
  rgb_t                        rgb;
  logic [LANES-1:0][SLOTS-1:0] word;
  logic                        load;

  cl_fmt_map u_map (
    .fmt_i (fmt_i),
    .pix_i (pix_i),
    .rgb_o (rgb)
  );

  cl_lane_pack u_pack (
    .rgb_i  (rgb),
    .fval_i (fval_i),
    .lval_i (lval_i),
    .dval_i (dval_i),
    .word_o (word)
  );

  cl_phase_gen #(.SLOTS(SLOTS), .HIGH_SLOTS(4), .LEAD_SLOTS(2)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_o    (load),
    .fwd_clk_o (fwd_clk_o)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    cl_lane_shift #(.SLOTS(SLOTS)) u_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .word_i (word[k]),
      .ser_o  (lane_o[k])
    );
  end
endmodule

// File: rtl/cl_video_serializer_chk.sv
module cl_video_serializer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] lane_i,
  input logic       fwd_clk_i
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (lane_i == 4'b0 && fwd_clk_i)
        else $error("lanes not idle in reset");
    end
  end

  assert_high_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fwd_clk_i) |=> fwd_clk_i ##1 fwd_clk_i ##1 fwd_clk_i ##1 !fwd_clk_i);

  assert_low_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fwd_clk_i) |=> !fwd_clk_i ##1 !fwd_clk_i ##1 fwd_clk_i);

  // first slot of a group: third high period after a rise
  assert_spare_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_clk_i && $past(fwd_clk_i) && $past(fwd_clk_i, 2) && !$past(fwd_clk_i, 3))
      |-> !lane_i[3]);
endmodule

bind cl_video_serializer cl_video_serializer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lane_i    (lane_o),
  .fwd_clk_i (fwd_clk_o)
);

// File: tb/cl_video_serializer_test.sv
`timescale 1ns/1ps
module cl_video_serializer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  fmt = '0;
  logic [23:0] pix = '0;
  logic        fval = 1'b0, lval = 1'b0, dval = 1'b0;
  logic [3:0]  lane;
  logic        fwd_clk;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [27:0] w;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cl_video_serializer uut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .pix_i(pix),
    .fval_i(fval), .lval_i(lval), .dval_i(dval),
    .lane_o(lane), .fwd_clk_o(fwd_clk)
  );

  function automatic logic [27:0] model(input logic [1:0] f, input logic [23:0] p,
                                        input logic fv, input logic lv, input logic dv);
    logic [7:0] r, g, b;
    logic [6:0] l0, l1, l2, l3;
    r = '0; g = '0; b = '0;
    case (f)
      2'd0: begin r = p[7:0]; g = p[15:8]; b = p[23:16]; end
      2'd1: begin r = p[7:0]; g = {2'b00, p[13:8]}; end
      2'd2: begin r = {p[1:0], 6'b0}; g = {2'b00, p[7:2]}; end
      default: begin r = p[7:0]; g = p[15:8]; end
    endcase
    l0 = {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
    l1 = {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
    l2 = {dv, fv, lv, b[5], b[4], b[3], b[2]};
    l3 = {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]};
    return {l3, l2, l1, l0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one group at a negedge; garble re-randomizes inputs after capture
  task automatic send(input logic [1:0] f, input logic [23:0] p, input logic fv,
                      input logic lv, input logic dv, input string tag, input bit garble);
    exp_t e;
    fmt = f; pix = p; fval = fv; lval = lv; dval = dv;
    e.w = model(f, p, fv, lv, dv);
    e.tag = tag;
    sb.push_back(e);
    repeat (6) begin
      @(negedge clk);
      if (garble) begin
        fmt = 2'($urandom); pix = 24'($urandom);
        fval = 1'($urandom); lval = 1'($urandom); dval = 1'($urandom);
      end
    end
    @(negedge clk);
  endtask

  // monitor: collect one group per seven bit periods after reset release
  initial begin
    @(posedge rst_n);
    forever begin
      logic [27:0] got;
      logic [6:0]  cpat;
      for (int s = 0; s < 7; s++) begin
        @(negedge clk);
        for (int k = 0; k < 4; k++) got[k*7 + (6 - s)] = lane[k];
        cpat[6 - s] = fwd_clk;
      end
      check(cpat == 7'b1100011, "R2 clock pattern", 32'(cpat), 32'h63);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(got == e.w, {"R3 ", e.tag}, 32'(got), 32'(e.w));
      end
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(lane == 4'b0 && fwd_clk == 1'b1, "R1 reset idle", {27'b0, lane, fwd_clk}, 32'h1);
    end
    pix = 24'hFFFFFF; fmt = 2'd0;
    @(negedge clk);
    rst_n = 1'b1;
    // R4 colour patterns, R3 slot placement
    send(2'd0, 24'hFFFFFF, 1, 1, 1, "R4 all ones", 0);
    send(2'd0, 24'hA5C3E1, 1, 1, 1, "R4 mixed", 0);
    for (int i = 0; i < 24; i++)
      send(2'd0, 24'h1 << i, 0, 0, 0, "R4 walking bit", 0);
    // R5 grey14, R10 unmapped bits random
    send(2'd1, 24'h003A5C, 1, 1, 1, "R5 grey14", 0);
    send(2'd1, {10'h3FF, 14'h2B71}, 1, 1, 1, "R5 R10 grey14 upper bits", 0);
    for (int i = 0; i < 6; i++)
      send(2'd1, 24'($urandom), 1, 1, 1, "R5 R10 grey14 random", 0);
    // R6 grey8
    send(2'd2, 24'h0000B6, 1, 1, 1, "R6 grey8", 0);
    send(2'd2, 24'hFFFF03, 1, 0, 1, "R6 R10 grey8 upper bits", 0);
    for (int i = 0; i < 6; i++)
      send(2'd2, 24'($urandom), 1, 1, 1, "R6 R10 grey8 random", 0);
    // R7 superframe
    send(2'd3, 24'h00F00F, 1, 1, 1, "R7 superframe", 0);
    send(2'd3, 24'hFF8421, 1, 1, 1, "R7 R10 superframe upper bits", 0);
    // R8 strobes in every format
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 8; s++)
        send(2'(f), 24'($urandom), s[2], s[1], s[0], "R8 strobes", 0);
    // R9 inputs changing mid-group
    for (int i = 0; i < 10; i++)
      send(2'(i % 4), 24'($urandom), 1'(i), 1'(i >> 1), 1, "R9 mid-group change", 1);
    send(2'd0, 24'h000000, 0, 0, 0, "R9 hold after garble", 0);
    repeat (14) @(negedge clk);
    check(sb.size() == 0, "R9 every group emitted", 32'(sb.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule